// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem-line side of a classic serial port. It owns a small control register that drives four handshake outputs: terminal ready, request to send, and two general-purpose outputs. It also holds a status register that reports four handshake inputs: clear to send, set ready, ring and carrier. The four inputs pass through a synchronizer chain and are compared against their last recorded levels. Any change sets a sticky change flag. A modem-status interrupt request is raised while any flag is set and the interrupt is enabled.

A self-test mode is selected by one control bit. In this mode the four external inputs are ignored and the handshake outputs are held low. The status levels are then taken from the control bits through a fixed cross-wiring. Software can exercise the whole change-detection path without touching the cable.

The host reaches both registers through one byte-wide port. A single select line picks control (0) or status (1). Reading the status register clears its change flags.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control register reads 0x08 and the status register reads 0xB0: carrier, set-ready and clear-to-send high, ring low, no change flags. `out2_out` is high, the other three outputs are low, and `irq_out` is low.
- R2: Outside self-test, status bits 7, 6, 5 and 4 show the synchronized carrier, ring, set-ready and clear-to-send inputs. The register reflects an input change at most three clock edges after the input moves.
- R3: Status bits 3, 1 and 0 latch on any change of carrier, set-ready and clear-to-send respectively, and stay set until read. Bit 2 latches only when the ring level goes from 1 to 0. A rising ring level sets no flag.
- R4: A read with `sel_stat` = 1 returns the current flags, and the change flags (bits 3:0) are clear on the next cycle unless a new change occurs.
- R5: A write with `sel_stat` = 0 loads control bits 4:0: bit 0 terminal ready, bit 1 request to send, bit 2 OUT1, bit 3 OUT2, bit 4 self-test. Bits 7:5 read as zero. Writes with `sel_stat` = 1 change nothing.
- R6: Outside self-test, `dtr_out`, `rts_out`, `out1_out` and `out2_out` follow control bits 0, 1, 2 and 3. In self-test all four are low from the cycle after the enabling write.
- R7: In self-test the status level bits take OUT2 as carrier (bit 7), OUT1 as ring (bit 6), terminal ready as set-ready (bit 5) and request to send as clear-to-send (bit 4). Changes on the external inputs have no effect.
- R8: `irq_out` is high exactly when `msi_en` is high and at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_stat | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears change flags on a status read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_in | input | 1 | Clear-to-send input, asynchronous |
| dsr_in | input | 1 | Set-ready input, asynchronous |
| ri_in | input | 1 | Ring input, asynchronous |
| dcd_in | input | 1 | Carrier input, asynchronous |
| dtr_out | output | 1 | Terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| out1_out | output | 1 | General-purpose output 1 |
| out2_out | output | 1 | General-purpose output 2 |
| irq_out | output | 1 | Modem-status interrupt request |

## Verification
The properties assume that `rst_n` is held low for at least two clock edges, so the synchronizer and the level register start from the idle pattern. They also assume that the strobes and `sel_stat` are steady around each rising edge. The stimulus changes every input, strobe and handshake line only on the falling edge. It holds each handshake level for several cycles, so that no pulse is shorter than the synchronizer latency. Before each status check it waits at least four cycles after any input or control change.

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_stat,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       msi_en,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       ri_in,
  input  logic       dcd_in,
  output logic       dtr_out,
  output logic       rts_out,
  output logic       out1_out,
  output logic       out2_out,
  output logic       irq_out
);

  localparam int          LVL_W   = 4;
  localparam int          CTL_W   = 5;
  localparam logic [3:0]  LVL_RST = 4'b1011;
  localparam logic [4:0]  CTL_RST = 5'b01000;

  logic [LVL_W-1:0] sync_q [SYNC_STAGES];
  logic [LVL_W-1:0] ext_lvl;
  logic [LVL_W-1:0] lb_lvl;
  logic [LVL_W-1:0] nxt_lvl;
  logic [LVL_W-1:0] diff;
  logic [LVL_W-1:0] new_dlt;
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] dlt_q;
  logic [CTL_W-1:0] ctl_q;
  logic             loop;
  logic             stat_rd;
  logic             ctl_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= LVL_RST;
    end else begin
      sync_q[0] <= {dcd_in, ri_in, dsr_in, cts_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign ext_lvl = sync_q[SYNC_STAGES-1];
  assign loop    = ctl_q[4];
  assign lb_lvl  = {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]};
  assign nxt_lvl = loop ? lb_lvl : ext_lvl;
  assign diff    = lvl_q ^ nxt_lvl;
  assign new_dlt = {diff[3], diff[2] & lvl_q[2] & ~nxt_lvl[2], diff[1], diff[0]};
  assign stat_rd = rd_en & sel_stat;
  assign ctl_wr  = wr_en & ~sel_stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      lvl_q <= LVL_RST;
      dlt_q <= '0;
    end else begin
      if (ctl_wr) ctl_q <= wdata[CTL_W-1:0];
      lvl_q <= nxt_lvl;
      dlt_q <= (stat_rd ? '0 : dlt_q) | new_dlt;
    end
  end

  assign rdata    = sel_stat ? {lvl_q, dlt_q} : {{(8-CTL_W){1'b0}}, ctl_q};
  assign dtr_out  = ctl_q[0] & ~loop;
  assign rts_out  = ctl_q[1] & ~loop;
  assign out1_out = ctl_q[2] & ~loop;
  assign out2_out = ctl_q[3] & ~loop;
  assign irq_out  = msi_en & (|dlt_q);

endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_stat,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic       msi_en,
  input logic       dtr_out,
  input logic       rts_out,
  input logic       out1_out,
  input logic       out2_out,
  input logic       irq_out,
  input logic [3:0] ext_lvl,
  input logic [3:0] lvl_q,
  input logic [3:0] dlt_q,
  input logic [4:0] ctl_q
);

  p_lvl_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_q[4]) |-> lvl_q == $past(ext_lvl));

  p_dcd_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q[3] != $past(lvl_q[3])) |-> dlt_q[3]);

  p_cts_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q[0] != $past(lvl_q[0])) |-> dlt_q[0]);

  p_ri_trail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt_q[2]) |-> $fell(lvl_q[2]));

  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en && sel_stat) && lvl_q == $past(lvl_q)) |-> dlt_q == 4'h0);

  p_quiet_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_stat && wdata[4]) |=> !(dtr_out || rts_out || out1_out || out2_out));

  p_loop_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_q[4]) |-> lvl_q == {$past(ctl_q[3]), $past(ctl_q[2]), $past(ctl_q[0]), $past(ctl_q[1])});

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq_out);

  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en && dlt_q != 4'h0) |-> irq_out);

endmodule

bind modem_ctl_stat modem_ctl_stat_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel_stat(sel_stat), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .msi_en(msi_en), .dtr_out(dtr_out), .rts_out(rts_out),
  .out1_out(out1_out), .out2_out(out2_out), .irq_out(irq_out),
  .ext_lvl(ext_lvl), .lvl_q(lvl_q), .dlt_q(dlt_q), .ctl_q(ctl_q)
);

// File: tb/modem_ctl_stat_tb_top.sv
module modem_ctl_stat_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_stat = 1'b0, wr_en = 1'b0, rd_en = 1'b0, msi_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cts_in = 1'b1, dsr_in = 1'b1, ri_in = 1'b0, dcd_in = 1'b1;
  logic       dtr_out, rts_out, out1_out, out2_out, irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] q_exp [$];
  string      q_tag [$];

  always #10 clk = ~clk;

  modem_ctl_stat dut_i (
    .clk(clk), .rst_n(rst_n), .sel_stat(sel_stat), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .msi_en(msi_en),
    .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
    .dtr_out(dtr_out), .rts_out(rts_out), .out1_out(out1_out), .out2_out(out2_out),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    sel_stat = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sel_stat = s; rd_en = 1'b1;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_outs(input string tag, input logic [3:0] exp);
    @(negedge clk);
    chk(tag, {4'h0, out2_out, out1_out, rts_out, dtr_out}, {4'h0, exp});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rd_en) begin
        if (q_exp.size() == 0) begin
          chk("monitor queue", 8'h01, 8'h00);
        end else begin
          chk(q_tag.pop_front(), rdata, q_exp.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h01, 8'h00);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    reg_rd(1'b0, 8'h08, "R1 control");
    reg_rd(1'b1, 8'hB0, "R1 status");
    chk("R1 irq", {7'h0, irq_out}, 8'h00);
    chk_outs("R1 outputs", 4'b1000);

    // R5 R6 control write
    reg_wr(1'b0, 8'h03);
    reg_rd(1'b0, 8'h03, "R5 control write");
    chk_outs("R6 outputs follow", 4'b0011);
    reg_wr(1'b1, 8'hFF);
    reg_rd(1'b0, 8'h03, "R5 status-address write ignored (control)");
    reg_rd(1'b1, 8'hB0, "R5 status-address write ignored (status)");
    reg_wr(1'b0, 8'hE7);
    reg_rd(1'b0, 8'h07, "R5 upper bits zero");
    chk_outs("R6 outputs OUT1", 4'b0111);

    // R2 R3 R4 R8 external changes
    cts_in = 1'b0;
    idle(4);
    chk("R8 masked irq", {7'h0, irq_out}, 8'h00);
    reg_rd(1'b1, 8'hA1, "R2 R3 cts change");
    reg_rd(1'b1, 8'hA0, "R4 flags cleared");
    msi_en = 1'b1;
    ri_in = 1'b1;
    idle(4);
    reg_rd(1'b1, 8'hE0, "R3 ring rise no flag");
    chk("R8 no flag no irq", {7'h0, irq_out}, 8'h00);
    ri_in = 1'b0;
    idle(4);
    chk("R8 irq on ring fall", {7'h0, irq_out}, 8'h01);
    reg_rd(1'b1, 8'hA4, "R3 ring trailing edge");
    chk("R4 R8 irq after read", {7'h0, irq_out}, 8'h00);
    dcd_in = 1'b0; dsr_in = 1'b0;
    idle(4);
    reg_rd(1'b1, 8'h0A, "R2 R3 carrier and set-ready");
    reg_rd(1'b1, 8'h00, "R4 cleared again");

    // R6 R7 self-test
    reg_wr(1'b0, 8'h1F);
    chk_outs("R6 self-test outputs low", 4'b0000);
    idle(3);
    reg_rd(1'b1, 8'hFB, "R7 self-test levels");
    reg_rd(1'b1, 8'hF0, "R4 self-test cleared");
    cts_in = 1'b1; dsr_in = 1'b1; dcd_in = 1'b1; ri_in = 1'b1;
    idle(5);
    reg_rd(1'b1, 8'hF0, "R7 external ignored");
    ri_in = 1'b0;
    reg_wr(1'b0, 8'h1B);
    idle(4);
    chk("R8 irq self-test", {7'h0, irq_out}, 8'h01);
    reg_rd(1'b1, 8'hB4, "R3 R7 OUT1 ring fall");
    reg_wr(1'b0, 8'h03);
    idle(4);
    reg_rd(1'b1, 8'hB0, "R2 leave self-test");
    chk_outs("R6 outputs restored", 4'b0011);

    idle(3);
    if (q_exp.size() != 0) chk("monitor drain", 8'h01, 8'h00);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule